// File: doc/BRIEF.md
# Multi-Target SPI Master With Select Hold

This block is a serial peripheral interface master that serves up to four peripheral selects from one shift engine. Every select carries its own settings: word length from 8 to 16 bits, clock divisor, idle clock level, sampling phase, and a hold flag. When the hold flag is set, the select stays driven between transfers, including across idle gaps, so that a peripheral sees one long framed exchange made of several words.

A producer (software or a DMA requester) writes 32-bit transmit words into a one-word holding slot. Each word carries the payload in its low bits, an optional target in bits 17:16, and an end-of-frame flag in bit 24. The target comes either from a fixed-select input or from the word itself, depending on the mode input. Received words land in a one-word receive register with ready and overrun flags. A size output tells an external DMA requester whether the active select moves bytes or halfwords.

Top module: `spi_hold_master`

## Requirements
- R1: Words of any length from 8 to 16 bits go out most significant bit first, and with `miso` looped to `mosi` the received word equals the low `bits` of the sent payload, for both phase settings (phase 0 samples on the leading edge, phase 1 on the trailing edge).
- R2: Each transfer gives exactly as many serial clock pulses as the select's word length, at every divisor, including divisor 1 and odd word lengths.
- R3: For a divisor N of 2 or more, the non-idle clock level lasts ceil(N/2) system clocks and the idle level between pulses lasts floor(N/2); divisor 1 gives one system clock per level.
- R4: A pending word aimed at a select whose divisor is 0 does not start: `tx_ready` and `tx_empty` stay low and no select is driven until the divisor is made non-zero.
- R5: `cs_n` is active low with at most one bit low; a select without hold is released when its word ends, and a select with hold stays low after the word ends, through an idle gap.
- R6: A word with bit 24 set releases a held select after its last bit, once no further word is pending; a word already pending keeps the select driven.
- R7: Starting a word on another target releases a previously held select in the same cycle the new select is driven.
- R8: With `fixed_mode` high the target is `fixed_cs`; with it low the target is bits 17:16 of the transmit word.
- R9: `tx_ready` falls in the cycle after an accepted write and rises one cycle after the word moves into the shifter, also for a second word to the same held select; every written word is sent exactly once.
- R10: `rx_ready` sets when a word completes and clears on `rx_rd`; `rx_overrun` sets when a word completes while the previous one is unread, and clears with the next read.
- R11: `dma_halfword` is 0 when the active select is set to 8 bits and 1 above 8; the active select is `fixed_cs` in fixed mode, otherwise the target of the latest started word.
- R12: `sclk` is 0 after reset, does not move while configuration is written, and changes only while a transfer runs or when a transfer begins on a select with a different idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Writes one select's settings |
| cfg_idx | input | 2 | Select whose settings are written |
| cfg_bits | input | 5 | Word length, clamped to 8..16 |
| cfg_div | input | 8 | Serial clock divisor, 0 disables |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | Sampling phase |
| cfg_hold | input | 1 | Keep select driven after a word |
| fixed_mode | input | 1 | 1: target from `fixed_cs`, 0: from word bits 17:16 |
| fixed_cs | input | 2 | Target in fixed mode |
| tx_we | input | 1 | Write strobe for the transmit word |
| tx_word | input | 32 | Payload 15:0, target 17:16, end flag 24 |
| tx_ready | output | 1 | Holding slot is free |
| tx_empty | output | 1 | Holding slot free and shifter idle |
| rx_rd | input | 1 | Read strobe for the receive register |
| rx_data | output | 16 | Last received word, right aligned |
| rx_ready | output | 1 | Unread word present |
| rx_overrun | output | 1 | A word was lost |
| dma_halfword | output | 1 | Active select moves halfwords |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low selects |

## Verification
The in-RTL properties assume `tx_we` is raised only while `tx_ready` is high, and that `miso` is stable around each sampling edge; the bench writes only after seeing `tx_ready` and loops `mosi` back to `miso`, which changes only on system clock edges. Settings written while a word is pending are assumed to apply at the next start, so the bench reconfigures only between words or while a word waits on a zero divisor. Read strobes are one cycle long and issued only when `rx_ready` is high.

// File: rtl/spi_hm_pkg.sv
package spi_hm_pkg;

    localparam int DATA_W   = 16;
    localparam int BITS_W   = 5;
    localparam int DIV_W    = 8;
    localparam int WORD_W   = 32;
    localparam int TGT_LSB  = 16;
    localparam int LAST_POS = 24;

    localparam logic [BITS_W-1:0] BITS_MIN = BITS_W'(8);
    localparam logic [BITS_W-1:0] BITS_MAX = BITS_W'(DATA_W);

    typedef struct packed {
        logic [BITS_W-1:0] bits;
        logic [DIV_W-1:0]  div;
        logic              cpol;
        logic              cpha;
        logic              hold;
    } cs_cfg_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              last;
    } tx_item_t;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_REST  = 2'd1,
        ENG_DRIVE = 2'd2
    } eng_state_t;

    function automatic logic [BITS_W-1:0] clamp_bits(input logic [BITS_W-1:0] b);
        if (b < BITS_MIN)      return BITS_MIN;
        else if (b > BITS_MAX) return BITS_MAX;
        else                   return b;
    endfunction

    function automatic logic [DIV_W-1:0] rest_len(input logic [DIV_W-1:0] d);
        if (d < DIV_W'(2)) return DIV_W'(1);
        return d >> 1;
    endfunction

    function automatic logic [DIV_W-1:0] drive_len(input logic [DIV_W-1:0] d);
        if (d < DIV_W'(2)) return DIV_W'(1);
        return DIV_W'((d >> 1) + DIV_W'(d[0]));
    endfunction

endpackage

// File: rtl/spi_hm_cfg.sv
module spi_hm_cfg
    import spi_hm_pkg::*;
#(
    parameter int NUM_CS = 4,
    localparam int CSW = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [CSW-1:0] wr_idx,
    input  cs_cfg_t        wr_cfg,
    input  logic [CSW-1:0] rd_idx_a,
    output cs_cfg_t        rd_cfg_a,
    input  logic [CSW-1:0] rd_idx_b,
    output cs_cfg_t        rd_cfg_b
);

    cs_cfg_t [NUM_CS-1:0] tbl;

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        cs_cfg_t q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q.bits <= BITS_MIN;
                q.div  <= '0;
                q.cpol <= 1'b0;
                q.cpha <= 1'b0;
                q.hold <= 1'b0;
            end else if (we && wr_idx == CSW'(i)) begin
                q      <= wr_cfg;
                q.bits <= clamp_bits(wr_cfg.bits);
            end
        end
        assign tbl[i] = q;
    end

    assign rd_cfg_a = tbl[rd_idx_a];
    assign rd_cfg_b = tbl[rd_idx_b];

endmodule

// File: rtl/spi_hm_engine.sv
module spi_hm_engine
    import spi_hm_pkg::*;
#(
    parameter int NUM_CS = 4,
    localparam int CSW = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go_i,
    input  tx_item_t          item_i,
    input  logic [CSW-1:0]    tgt_i,
    input  cs_cfg_t           cfg_i,
    input  logic              pend_i,
    input  logic              miso_i,
    output logic              take_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rx_word_o,
    output logic [CSW-1:0]    cur_cs_o,
    output logic              sclk_o,
    output logic              mosi_o,
    output logic [NUM_CS-1:0] cs_n_o
);

    eng_state_t        st;
    logic [DIV_W-1:0]  cnt;
    logic [DIV_W-1:0]  len_rest;
    logic [DIV_W-1:0]  len_drive;
    logic [BITS_W-1:0] bits_left;
    logic [BITS_W-1:0] cur_bits;
    logic [BITS_W-1:0] lead_cnt;
    logic [DATA_W:0]   tx_sh;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] rx_in;
    logic [DATA_W-1:0] aligned;
    logic              cur_pol;
    logic              cur_pha;
    logic              cur_hold;
    logic              cur_last;
    logic              cs_on;
    logic [CSW-1:0]    cs_idx;
    logic              rel_pend;
    logic              sclk_q;

    assign take_o  = (st == ENG_IDLE) && go_i;
    assign busy_o  = (st != ENG_IDLE);
    assign rx_in   = {rx_sh[DATA_W-2:0], miso_i};
    assign aligned = item_i.data << (BITS_W'(DATA_W) - cfg_i.bits);
    assign sclk_o  = sclk_q;
    assign mosi_o  = tx_sh[DATA_W];
    assign cur_cs_o = cs_idx;

    for (genvar i = 0; i < NUM_CS; i++) begin : g_sel
        assign cs_n_o[i] = !(cs_on && cs_idx == CSW'(i));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ENG_IDLE;
            cnt       <= '0;
            len_rest  <= DIV_W'(1);
            len_drive <= DIV_W'(1);
            bits_left <= '0;
            cur_bits  <= BITS_MIN;
            lead_cnt  <= '0;
            tx_sh     <= '0;
            rx_sh     <= '0;
            rx_word_o <= '0;
            done_o    <= 1'b0;
            cur_pol   <= 1'b0;
            cur_pha   <= 1'b0;
            cur_hold  <= 1'b0;
            cur_last  <= 1'b0;
            cs_on     <= 1'b0;
            cs_idx    <= '0;
            rel_pend  <= 1'b0;
            sclk_q    <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (st)
                ENG_IDLE: begin
                    if (take_o) begin
                        st        <= ENG_REST;
                        cnt       <= rest_len(cfg_i.div) - DIV_W'(1);
                        len_rest  <= rest_len(cfg_i.div);
                        len_drive <= drive_len(cfg_i.div);
                        bits_left <= cfg_i.bits;
                        cur_bits  <= cfg_i.bits;
                        lead_cnt  <= '0;
                        cur_pol   <= cfg_i.cpol;
                        cur_pha   <= cfg_i.cpha;
                        cur_hold  <= cfg_i.hold;
                        cur_last  <= item_i.last;
                        cs_on     <= 1'b1;
                        cs_idx    <= tgt_i;
                        rel_pend  <= 1'b0;
                        sclk_q    <= cfg_i.cpol;
                        rx_sh     <= '0;
                        tx_sh     <= cfg_i.cpha ? {1'b0, aligned} : {aligned, 1'b0};
                    end else if (rel_pend && !pend_i) begin
                        cs_on    <= 1'b0;
                        rel_pend <= 1'b0;
                    end
                end
                ENG_REST: begin
                    if (cnt == '0) begin
                        st       <= ENG_DRIVE;
                        cnt      <= len_drive - DIV_W'(1);
                        sclk_q   <= ~cur_pol;
                        lead_cnt <= lead_cnt + BITS_W'(1);
                        if (cur_pha) tx_sh <= tx_sh << 1;
                        else         rx_sh <= rx_in;
                    end else begin
                        cnt <= cnt - DIV_W'(1);
                    end
                end
                ENG_DRIVE: begin
                    if (cnt == '0) begin
                        sclk_q <= cur_pol;
                        if (cur_pha) rx_sh <= rx_in;
                        else         tx_sh <= tx_sh << 1;
                        if (bits_left == BITS_W'(1)) begin
                            st        <= ENG_IDLE;
                            done_o    <= 1'b1;
                            rx_word_o <= cur_pha ? rx_in : rx_sh;
                            if (!cur_hold)     cs_on    <= 1'b0;
                            else if (cur_last) rel_pend <= 1'b1;
                        end else begin
                            st        <= ENG_REST;
                            cnt       <= len_rest - DIV_W'(1);
                            bits_left <= bits_left - BITS_W'(1);
                        end
                    end else begin
                        cnt <= cnt - DIV_W'(1);
                    end
                end
                default: st <= ENG_IDLE;
            endcase
        end
    end

    // R2: leading edges counted separately from the bit counter match the word length
    a_r2_pulse_count: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (lead_cnt == cur_bits));

    // R12: the serial clock holds its level while the engine rests between words
    a_r12_sclk_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && $past(!busy_o)) |-> $stable(sclk_q));

    // R5: never more than one select driven
    a_r5_one_select: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n_o));

    // R1: the bit counter stays inside the legal word length while busy
    a_r1_bits_in_range: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (bits_left >= BITS_W'(1) && bits_left <= BITS_MAX));

    // R6: a held select is let go only when nothing waits in the holding slot
    a_r6_release_when_empty: assert property (@(posedge clk) disable iff (rst)
        ($past(cs_on) && !cs_on && $past(!busy_o)) |-> $past(!pend_i));

endmodule

// File: rtl/spi_hm_rxbuf.sv
module spi_hm_rxbuf
    import spi_hm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done_i,
    input  logic [DATA_W-1:0] word_i,
    input  logic              rd_i,
    output logic [DATA_W-1:0] data_o,
    output logic              ready_o,
    output logic              overrun_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_o    <= '0;
            ready_o   <= 1'b0;
            overrun_o <= 1'b0;
        end else if (done_i) begin
            data_o    <= word_i;
            ready_o   <= 1'b1;
            overrun_o <= overrun_o | (ready_o & ~rd_i);
        end else if (rd_i) begin
            ready_o   <= 1'b0;
            overrun_o <= 1'b0;
        end
    end

    // R10: a lost word is only flagged alongside an unread one
    a_r10_overrun_with_ready: assert property (@(posedge clk) disable iff (rst)
        overrun_o |-> ready_o);

endmodule

// File: rtl/spi_hold_master.sv
module spi_hold_master
    import spi_hm_pkg::*;
#(
    parameter int NUM_CS = 4,
    localparam int CSW = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CSW-1:0]    cfg_idx,
    input  logic [BITS_W-1:0] cfg_bits,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_hold,
    input  logic              fixed_mode,
    input  logic [CSW-1:0]    fixed_cs,
    input  logic              tx_we,
    input  logic [WORD_W-1:0] tx_word,
    output logic              tx_ready,
    output logic              tx_empty,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              rx_overrun,
    output logic              dma_halfword,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_n
);

    tx_item_t          hold_item;
    logic [CSW-1:0]    hold_tgt;
    logic              hold_full;
    logic [CSW-1:0]    tgt;
    logic [CSW-1:0]    cur_cs;
    logic [CSW-1:0]    size_sel;
    cs_cfg_t           wr_cfg;
    cs_cfg_t           tgt_cfg;
    cs_cfg_t           size_cfg;
    logic              go;
    logic              take;
    logic              busy;
    logic              done;
    logic [DATA_W-1:0] rx_word;
    logic              unused_bits;

    assign unused_bits = ^{tx_word[WORD_W-1:LAST_POS+1],
                           tx_word[LAST_POS-1:TGT_LSB+CSW]};

    assign wr_cfg = '{bits: cfg_bits, div: cfg_div, cpol: cfg_cpol,
                      cpha: cfg_cpha, hold: cfg_hold};

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_item <= '0;
            hold_tgt  <= '0;
            hold_full <= 1'b0;
        end else if (take) begin
            hold_full <= 1'b0;
        end else if (tx_we && !hold_full) begin
            hold_item.data <= tx_word[DATA_W-1:0];
            hold_item.last <= tx_word[LAST_POS];
            hold_tgt       <= tx_word[TGT_LSB +: CSW];
            hold_full      <= 1'b1;
        end
    end

    assign tgt      = fixed_mode ? fixed_cs : hold_tgt;
    assign size_sel = fixed_mode ? fixed_cs : cur_cs;
    assign go       = hold_full && (tgt_cfg.div != '0);
    assign tx_ready = !hold_full;
    assign tx_empty = !hold_full && !busy;
    assign dma_halfword = (size_cfg.bits > BITS_MIN);

    spi_hm_cfg #(.NUM_CS(NUM_CS)) cfg_i (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .wr_idx   (cfg_idx),
        .wr_cfg   (wr_cfg),
        .rd_idx_a (tgt),
        .rd_cfg_a (tgt_cfg),
        .rd_idx_b (size_sel),
        .rd_cfg_b (size_cfg)
    );

    spi_hm_engine #(.NUM_CS(NUM_CS)) eng_i (
        .clk       (clk),
        .rst       (rst),
        .go_i      (go),
        .item_i    (hold_item),
        .tgt_i     (tgt),
        .cfg_i     (tgt_cfg),
        .pend_i    (hold_full),
        .miso_i    (miso),
        .take_o    (take),
        .busy_o    (busy),
        .done_o    (done),
        .rx_word_o (rx_word),
        .cur_cs_o  (cur_cs),
        .sclk_o    (sclk),
        .mosi_o    (mosi),
        .cs_n_o    (cs_n)
    );

    spi_hm_rxbuf rx_i (
        .clk       (clk),
        .rst       (rst),
        .done_i    (done),
        .word_i    (rx_word),
        .rd_i      (rx_rd),
        .data_o    (rx_data),
        .ready_o   (rx_ready),
        .overrun_o (rx_overrun)
    );

    // R9: the slot frees in the cycle after the shifter takes the word
    a_r9_ready_after_take: assert property (@(posedge clk) disable iff (rst)
        take |=> tx_ready);

    // R4: nothing starts toward a select whose divisor is zero
    a_r4_no_start_div0: assert property (@(posedge clk) disable iff (rst)
        (hold_full && tgt_cfg.div == '0) |=> (hold_full || $past(take)) && !(!busy && $past(!busy) && $fell(hold_full)));

endmodule

// File: tb/spi_hold_master_tb_top.sv
module spi_hold_master_tb_top;

    typedef struct {
        int unsigned data;
        int          bits;
        bit          pol;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [4:0]  cfg_bits = 5'd8;
    logic [7:0]  cfg_div = '0;
    logic        cfg_cpol = 1'b0;
    logic        cfg_cpha = 1'b0;
    logic        cfg_hold = 1'b0;
    logic        fixed_mode = 1'b1;
    logic [1:0]  fixed_cs = '0;
    logic        tx_we = 1'b0;
    logic [31:0] tx_word = '0;
    logic        tx_ready, tx_empty;
    logic        rx_rd = 1'b0;
    logic [15:0] rx_data;
    logic        rx_ready, rx_overrun, dma_halfword;
    logic        sclk, mosi, miso;
    logic [3:0]  cs_n;

    assign miso = mosi;

    always #10 clk = ~clk;

    spi_hold_master dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_bits(cfg_bits), .cfg_div(cfg_div), .cfg_cpol(cfg_cpol),
        .cfg_cpha(cfg_cpha), .cfg_hold(cfg_hold), .fixed_mode(fixed_mode),
        .fixed_cs(fixed_cs), .tx_we(tx_we), .tx_word(tx_word),
        .tx_ready(tx_ready), .tx_empty(tx_empty), .rx_rd(rx_rd),
        .rx_data(rx_data), .rx_ready(rx_ready), .rx_overrun(rx_overrun),
        .dma_halfword(dma_halfword), .sclk(sclk), .mosi(mosi), .miso(miso),
        .cs_n(cs_n)
    );

    int   errors = 0;
    int   checks = 0;
    bit   finished = 0;
    exp_t q[$];
    int   bits_of[4];
    bit   pol_of[4];
    bit   mon_en = 1;
    int   pulses = 0;
    int   hi_run = 0, lo_run = 0, last_hi = 0, last_lo = 0;
    bit   in_pulse = 0;
    logic prev_sclk = 1'b0;
    logic [3:0] seen = '0;
    int   cs1_hi = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // scoreboard monitor: pulse counting, select tracking, word comparison
    always @(negedge clk) begin
        if (!rst) begin
            bit pol;
            pol = (q.size() > 0) ? q[0].pol : 1'b0;
            if (prev_sclk == pol && sclk != pol) begin
                if (pulses > 0) last_lo = lo_run;
                pulses++;
                in_pulse = 1;
                hi_run = 0;
            end
            if (sclk != pol && in_pulse) hi_run++;
            if (sclk == pol) begin
                if (in_pulse) begin
                    last_hi = hi_run;
                    in_pulse = 0;
                    lo_run = 0;
                end
                lo_run++;
            end
            prev_sclk = sclk;
            seen = seen | ~cs_n;
            if (cs_n[1]) cs1_hi++;
            if (mon_en) begin
                if (rx_ready) begin
                    if (q.size() == 0) begin
                        check(0, "R9", "word received with none outstanding", rx_data, 0);
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        check(rx_data == e.data[15:0], "R1", "loopback word", rx_data, e.data);
                        check(pulses == e.bits, "R2", "clock pulse count", pulses, e.bits);
                    end
                    pulses = 0;
                    rx_rd = 1'b1;
                end else begin
                    rx_rd = 1'b0;
                end
            end
        end
    end

    task automatic cfg_write(input int idx, input int bits, input int div,
                             input bit pol, input bit pha, input bit hld);
        @(negedge clk);
        cfg_idx = 2'(idx); cfg_bits = 5'(bits); cfg_div = 8'(div);
        cfg_cpol = pol; cfg_cpha = pha; cfg_hold = hld; cfg_we = 1'b1;
        bits_of[idx] = bits; pol_of[idx] = pol;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input int unsigned w, input int tgt, input bit push);
        exp_t e;
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_word = w; tx_we = 1'b1;
        if (push) begin
            e.bits = bits_of[tgt];
            e.pol  = pol_of[tgt];
            e.data = w & ((32'd1 << e.bits) - 1);
            q.push_back(e);
        end
        @(negedge clk);
        tx_we = 1'b0;
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (!(tx_empty && q.size() == 0 && !rx_ready)) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(tx_ready == 1'b1, "R9", "tx_ready after reset", tx_ready, 1);
        check(tx_empty == 1'b1, "R9", "tx_empty after reset", tx_empty, 1);
        check(rx_ready == 1'b0, "R10", "rx_ready after reset", rx_ready, 0);
        check(cs_n == 4'hF, "R5", "selects after reset", cs_n, 4'hF);
        check(sclk == 1'b0, "R12", "sclk after reset", sclk, 0);

        cfg_write(0, 8, 4, 0, 0, 0);
        cfg_write(1, 12, 2, 1, 1, 1);
        cfg_write(2, 9, 1, 0, 1, 0);
        cfg_write(3, 16, 5, 1, 0, 1);
        check(sclk == 1'b0, "R12", "sclk still idle after configuration", sclk, 0);
        check(pulses == 0, "R12", "no toggles during configuration", pulses, 0);

        // R11 fixed mode size output
        fixed_cs = 2'd0; @(negedge clk);
        check(dma_halfword == 1'b0, "R11", "8-bit select gives byte", dma_halfword, 0);
        fixed_cs = 2'd2; @(negedge clk);
        check(dma_halfword == 1'b1, "R11", "9-bit select gives halfword", dma_halfword, 1);

        // R9 ready timing and R5 non-hold release
        fixed_cs = 2'd0;
        send(32'h0000_00A5, 0, 1);
        check(tx_ready == 1'b0, "R9", "tx_ready low after write", tx_ready, 0);
        @(negedge clk);
        check(tx_ready == 1'b1, "R9", "tx_ready back once shifter takes word", tx_ready, 1);
        check(tx_empty == 1'b0, "R9", "tx_empty low while shifting", tx_empty, 0);
        wait_done();
        check(cs_n == 4'hF, "R5", "non-hold select released", cs_n, 4'hF);

        // R3 half-period lengths at divisor 5
        fixed_cs = 2'd3;
        send(32'h0000_C3A5, 3, 1);
        wait_done();
        check(last_hi == 3, "R3", "driven level length div5", last_hi, 3);
        check(last_lo == 2, "R3", "rest level length div5", last_lo, 2);
        send(32'h0100_5A5A, 3, 1);
        wait_done();
        check(cs_n == 4'hF, "R6", "end flag releases held select", cs_n, 4'hF);

        // R1/R2 every word length at divisor 1, both phases
        fixed_cs = 2'd2;
        for (int b = 8; b <= 16; b++) begin
            cfg_write(2, b, 1, 0, b[0], 0);
            send(32'h0000_B6D9 ^ (b * 32'h0000_1357), 2, 1);
            wait_done();
        end
        check(last_hi == 1, "R3", "divisor 1 driven level length", last_hi, 1);

        // R5/R9 hold across idle gap, two words to one held select
        fixed_cs = 2'd1;
        send(32'h0000_0ABC, 1, 1);
        wait_done();
        repeat (10) @(negedge clk);
        check(cs_n == 4'b1101, "R5", "held select across idle gap", cs_n, 4'b1101);
        send(32'h0000_0123, 1, 1);
        wait_done();
        check(cs_n == 4'b1101, "R9", "held after second word", cs_n, 4'b1101);

        // R6 end flag with a word already pending keeps select
        cs1_hi = 0;
        send(32'h0100_0F0F, 1, 1);
        send(32'h0000_0777, 1, 1);
        wait_done();
        check(cs1_hi == 0, "R6", "pending word keeps select driven", cs1_hi, 0);
        check(cs_n == 4'b1101, "R6", "select still held after plain word", cs_n, 4'b1101);

        // R7 new target releases the held one
        fixed_cs = 2'd3;
        send(32'h0000_1234, 3, 1);
        wait_done();
        check(cs_n == 4'b0111, "R7", "switch to other held target", cs_n, 4'b0111);
        send(32'h0100_4321, 3, 1);
        wait_done();
        check(cs_n == 4'hF, "R6", "end flag release after switch", cs_n, 4'hF);

        // R8 variable mode, R11 size follows started target
        fixed_mode = 1'b0;
        fixed_cs = 2'd1;
        seen = '0;
        send(32'h0002_ABCD, 2, 1);
        wait_done();
        check(seen == 4'b0100, "R8", "word field selects target 2", seen, 4'b0100);
        check(dma_halfword == 1'b1, "R11", "size after 16-bit target", dma_halfword, 1);
        seen = '0;
        send(32'h0000_0066, 0, 1);
        wait_done();
        check(seen == 4'b0001, "R8", "word field selects target 0", seen, 4'b0001);
        check(dma_halfword == 1'b0, "R11", "size after 8-bit target", dma_halfword, 0);
        fixed_mode = 1'b1;

        // R4 zero divisor blocks start
        cfg_write(2, 10, 0, 0, 0, 0);
        fixed_cs = 2'd2;
        send(32'h0000_02AA, 2, 1);
        repeat (40) @(negedge clk);
        check(tx_ready == 1'b0, "R4", "word held at divisor 0", tx_ready, 0);
        check(tx_empty == 1'b0, "R4", "tx_empty low at divisor 0", tx_empty, 0);
        check(cs_n == 4'hF, "R4", "no select at divisor 0", cs_n, 4'hF);
        cfg_write(2, 10, 3, 0, 0, 0);
        wait_done();
        check(q.size() == 0, "R4", "word sent after divisor set", q.size(), 0);

        // R10 overrun
        mon_en = 1'b0;
        @(negedge clk); rx_rd = 1'b0;
        fixed_cs = 2'd0;
        send(32'h0000_0011, 0, 0);
        send(32'h0000_0022, 0, 0);
        @(negedge clk);
        while (!tx_empty) @(negedge clk);
        repeat (3) @(negedge clk);
        check(rx_ready == 1'b1, "R10", "ready with unread words", rx_ready, 1);
        check(rx_overrun == 1'b1, "R10", "overrun on second word", rx_overrun, 1);
        check(rx_data == 16'h0022, "R10", "latest word kept", rx_data, 16'h0022);
        rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
        check(rx_ready == 1'b0, "R10", "read clears ready", rx_ready, 0);
        check(rx_overrun == 1'b0, "R10", "read clears overrun", rx_overrun, 0);
        pulses = 0;
        mon_en = 1'b1;

        repeat (5) @(negedge clk);
        check(q.size() == 0, "R9", "no word outstanding at end", q.size(), 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule